// File: doc/BRIEF.md
# Bounds-Checked Register Stack

This block is a last-in first-out store of sixteen 8-bit words. A top pointer always holds the address of the word on top of the stack. A push moves the pointer up one place and writes the incoming word at the new address. A pop reads the word at the pointer and then moves the pointer down one place. The word read out appears one cycle after the pop is accepted.

Two limit registers set a window inside the array: a floor and a ceiling. Every access is checked against this window. The stack is empty when the pointer sits one below the floor, and full when the pointer equals the ceiling. A new pair of limits can be loaded whenever no push or pop is requested in the same cycle. A successful load empties the stack.

A request that would cross a limit, or that conflicts with another request, is refused. A refused request changes nothing and raises a single-cycle error pulse.

Occupancy is tracked by a three-state machine:
- `ST_EMPTY` moves to `ST_PART` on a push, or to `ST_FULL` on a push when floor equals ceiling.
- `ST_PART` moves to `ST_FULL` on a push that lands on the ceiling, and to `ST_EMPTY` on a pop taken from the floor. Any other push or pop keeps it in `ST_PART`.
- `ST_FULL` moves to `ST_EMPTY` on a pop when floor equals ceiling, and to `ST_PART` on any other pop.
- An accepted load sends every state to `ST_EMPTY`.

Top module: `bstack_top`

## Requirements
- R1: An accepted pop returns the most recently pushed word that has not yet been popped. The word appears on `rdata_o` with `rvalid_o` high for exactly one cycle, in the cycle after the pop. `rvalid_o` is low in every other cycle.
- R2: `sp_o` is a 5-bit address of the top word. An accepted push adds one to it and an accepted pop subtracts one. The empty value is floor − 1 taken modulo 32, so it reads 31 when the floor is 0.
- R3: After reset the floor is 0 and the ceiling is 15. At reset `sp_o` = 31, `empty_o` = 1, `full_o` = 0, `err_o` = 0 and `rvalid_o` = 0.
- R4: `empty_o` is high exactly when the pointer equals floor − 1. `full_o` is high exactly when the pointer equals the ceiling. The two are never high together.
- R5: A push while full is refused: the pointer and the stored words stay unchanged, and `err_o` is high for the next cycle only.
- R6: A pop while empty is refused: no `rvalid_o`, the pointer stays unchanged, and `err_o` pulses for one cycle.
- R7: Push and pop requested in the same cycle is an error. Neither operation takes place, and `err_o` pulses.
- R8: A load with no push or pop in the same cycle, and with floor ≤ ceiling, takes both limits. The stack becomes empty, with `sp_o` = floor − 1.
- R9: A load together with a push or pop, or a load with floor > ceiling, is refused. The limits, the pointer and the stored words stay unchanged, and `err_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| wdata_i | input | 8 | Word to push |
| load_i | input | 1 | Load new limits |
| floor_i | input | 4 | New lowest address |
| ceil_i | input | 4 | New highest address |
| rdata_o | output | 8 | Popped word |
| rvalid_o | output | 1 | `rdata_o` valid this cycle |
| sp_o | output | 5 | Top-of-stack pointer |
| full_o | output | 1 | Pointer at ceiling |
| empty_o | output | 1 | Pointer at floor − 1 |
| err_o | output | 1 | Previous request refused |

## Verification
The hardest situations to reach are a window narrowed to a single word and a floor of zero. In the first, one push takes the stack straight from empty to full. In the second, the empty pointer wraps to 31. The stimulus reaches both by loading narrow and zero-based limits and then driving the stack past each edge. A long pseudo-random phase then mixes pushes, pops, conflicting requests and occasional loads with arbitrary limits, including illegal ones. Every cycle is compared with a queue-free array model.

// File: rtl/bstk_pkg.sv
package bstk_pkg;
    typedef enum logic [1:0] {ST_EMPTY, ST_PART, ST_FULL} occ_t;
    typedef enum logic [1:0] {OP_NONE, OP_PUSH, OP_POP, OP_LOAD} op_t;
endpackage

// File: rtl/bstk_dec.sv
module bstk_dec
    import bstk_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          push,
    input  logic          pop,
    input  logic          load,
    input  logic [AW-1:0] new_floor,
    input  logic [AW-1:0] new_ceil,
    input  occ_t          state,
    output op_t           op,
    output logic          reject
);
    always_comb begin
        op     = OP_NONE;
        reject = 1'b0;
        if (load) begin
            if (push || pop || (new_floor > new_ceil)) reject = 1'b1;
            else                                       op     = OP_LOAD;
        end else if (push && pop) begin
            reject = 1'b1;
        end else if (push) begin
            if (state == ST_FULL) reject = 1'b1;
            else                  op     = OP_PUSH;
        end else if (pop) begin
            if (state == ST_EMPTY) reject = 1'b1;
            else                   op     = OP_POP;
        end
    end
endmodule

// File: rtl/bstk_ctrl.sv
module bstk_ctrl
    import bstk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_t           op,
    input  logic          reject,
    input  logic [AW-1:0] new_floor,
    input  logic [AW-1:0] new_ceil,
    output occ_t          state,
    output logic [PW-1:0] sp,
    output logic          err
);
    localparam logic [AW-1:0] CEIL_RST = AW'(DEPTH - 1);

    logic [AW-1:0] floor_q, ceil_q;
    logic [PW-1:0] sp_up, floor_w, ceil_w;
    occ_t          next_state;

    assign sp_up   = sp + PW'(1);
    assign floor_w = {1'b0, floor_q};
    assign ceil_w  = {1'b0, ceil_q};

    always_comb begin
        next_state = state;
        unique case (state)
            ST_EMPTY: if (op == OP_PUSH)
                          next_state = (floor_q == ceil_q) ? ST_FULL : ST_PART;
            ST_PART: begin
                if (op == OP_PUSH)
                    next_state = (sp_up == ceil_w) ? ST_FULL : ST_PART;
                else if (op == OP_POP)
                    next_state = (sp == floor_w) ? ST_EMPTY : ST_PART;
            end
            ST_FULL: if (op == OP_POP)
                         next_state = (sp == floor_w) ? ST_EMPTY : ST_PART;
            default: next_state = ST_EMPTY;
        endcase
        if (op == OP_LOAD) next_state = ST_EMPTY;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= next_state;
    end

    // pointer, limits and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            floor_q <= '0;
            ceil_q  <= CEIL_RST;
            sp      <= '1;
            err     <= 1'b0;
        end else begin
            err <= reject;
            unique case (op)
                OP_PUSH: sp <= sp_up;
                OP_POP:  sp <= sp - PW'(1);
                OP_LOAD: begin
                    floor_q <= new_floor;
                    ceil_q  <= new_ceil;
                    sp      <= {1'b0, new_floor} - PW'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bstk_mem.sv
module bstk_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/bstack_top.sv
module bstack_top
    import bstk_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          load_i,
    input  logic [AW-1:0] floor_i,
    input  logic [AW-1:0] ceil_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o,
    output logic [PW-1:0] sp_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          err_o
);
    op_t           op;
    logic          reject;
    occ_t          state;
    logic [PW-1:0] sp;
    logic [PW-1:0] sp_up;

    assign sp_up = sp + PW'(1);

    bstk_dec #(.AW(AW)) u_dec (
        .push(push_i), .pop(pop_i), .load(load_i),
        .new_floor(floor_i), .new_ceil(ceil_i),
        .state(state), .op(op), .reject(reject)
    );

    bstk_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op), .reject(reject),
        .new_floor(floor_i), .new_ceil(ceil_i),
        .state(state), .sp(sp), .err(err_o)
    );

    bstk_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(op == OP_PUSH), .wr_addr(sp_up[AW-1:0]), .wr_data(wdata_i),
        .rd_en(op == OP_POP), .rd_addr(sp[AW-1:0]),
        .rd_data(rdata_o), .rd_valid(rvalid_o)
    );

    assign sp_o    = sp;
    assign full_o  = (state == ST_FULL);
    assign empty_o = (state == ST_EMPTY);
endmodule

// File: rtl/bstk_chk.sv
module bstk_chk #(
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic          load_i,
    input logic          rvalid_o,
    input logic [PW-1:0] sp_o,
    input logic          full_o,
    input logic          empty_o,
    input logic          err_o
);
    AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o)); // R4

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !load_i && !full_o) |=> (sp_o == $past(sp_o) + PW'(1)) && !err_o); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !load_i && full_o) |=> err_o && $stable(sp_o) && full_o); // R5

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !load_i && empty_o) |=> err_o && !rvalid_o && $stable(sp_o)); // R6

    AST_BOTH_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> err_o && !rvalid_o && $stable(sp_o)); // R7

    AST_LOAD_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (push_i || pop_i)) |=> err_o && $stable(sp_o)); // R9

    AST_RVALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && $past(rst_n)) |-> $past(pop_i && !push_i && !load_i && !empty_o)); // R1
endmodule

bind bstack_top bstk_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .load_i(load_i),
    .rvalid_o(rvalid_o), .sp_o(sp_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
);

// File: tb/sim_bstack_top.sv
`timescale 1ns/1ps
module sim_bstack_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       push_i, pop_i, load_i;
    logic [7:0] wdata_i;
    logic [3:0] floor_i, ceil_i;
    logic [7:0] rdata_o;
    logic       rvalid_o, full_o, empty_o, err_o;
    logic [4:0] sp_o;

    int n_checks = 0;
    int n_errors = 0;

    // reference model
    int m_mem [16];
    int m_sp, m_lo, m_hi, m_rd;
    bit m_err, m_rv;

    always #2.5 clk = ~clk;

    bstack_top u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .wdata_i(wdata_i),
        .load_i(load_i), .floor_i(floor_i), .ceil_i(ceil_i), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .sp_o(sp_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(bit p, bit q, bit ld, int wd, int lo, int hi);
        string tag;
        bit    full_m, empty_m;
        @(negedge clk);
        push_i = p; pop_i = q; load_i = ld;
        wdata_i = 8'(wd); floor_i = 4'(lo); ceil_i = 4'(hi);
        @(posedge clk);
        full_m  = (m_sp == m_hi);
        empty_m = (m_sp == m_lo - 1);
        m_err = 0; m_rv = 0; tag = "R2";
        if (ld) begin
            if (p || q || lo > hi) begin m_err = 1; tag = "R9"; end
            else begin m_lo = lo; m_hi = hi; m_sp = lo - 1; tag = "R8"; end
        end else if (p && q) begin
            m_err = 1; tag = "R7";
        end else if (p) begin
            if (full_m) begin m_err = 1; tag = "R5"; end
            else begin m_sp++; m_mem[m_sp] = wd & 255; end
        end else if (q) begin
            if (empty_m) begin m_err = 1; tag = "R6"; end
            else begin m_rd = m_mem[m_sp]; m_rv = 1; m_sp--; end
        end
        #1;
        chk(sp_o == 5'(m_sp), {tag, " sp_o"}, int'(sp_o), m_sp & 31);
        chk(err_o == m_err, {tag, " err_o"}, int'(err_o), int'(m_err));
        chk(empty_o == (m_sp == m_lo - 1), "R4 empty_o", int'(empty_o), int'(m_sp == m_lo - 1));
        chk(full_o == (m_sp == m_hi), "R4 full_o", int'(full_o), int'(m_sp == m_hi));
        chk(rvalid_o == m_rv, "R1 rvalid_o", int'(rvalid_o), int'(m_rv));
        if (m_rv) chk(rdata_o == 8'(m_rd), "R1 rdata_o", int'(rdata_o), m_rd);
        push_i = 0; pop_i = 0; load_i = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 0; push_i = 0; pop_i = 0; load_i = 0;
        wdata_i = 0; floor_i = 0; ceil_i = 0;
        m_sp = -1; m_lo = 0; m_hi = 15; m_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R3 reset state
        chk(sp_o == 5'd31, "R3 sp_o", int'(sp_o), 31);
        chk(empty_o == 1'b1, "R3 empty_o", int'(empty_o), 1);
        chk(full_o == 1'b0, "R3 full_o", int'(full_o), 0);
        chk(err_o == 1'b0, "R3 err_o", int'(err_o), 0);
        chk(rvalid_o == 1'b0, "R3 rvalid_o", int'(rvalid_o), 0);

        // fill the reset window (R3 limits), overflow (R5), drain, underflow (R6)
        for (int i = 0; i < 16; i++) step(1, 0, 0, i * 7 + 3, 0, 0);
        step(1, 0, 0, 8'hEE, 0, 0);
        for (int i = 0; i < 17; i++) step(0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);

        // R7 simultaneous push and pop
        step(1, 0, 0, 8'h11, 0, 0);
        step(1, 0, 0, 8'h22, 0, 0);
        step(1, 1, 0, 8'h33, 0, 0);
        step(0, 1, 0, 0, 0, 0);

        // R9 refused loads
        step(1, 0, 1, 8'h44, 2, 9);
        step(0, 1, 1, 0, 2, 9);
        step(0, 0, 1, 0, 9, 3);
        step(0, 1, 0, 0, 0, 0);

        // R8 narrow window 5..7
        step(0, 0, 1, 0, 5, 7);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 8'hA0 + i, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 0);

        // single-word window and floor-zero window
        step(0, 0, 1, 0, 6, 6);
        step(1, 0, 0, 8'h5A, 0, 0);
        step(1, 0, 0, 8'h5B, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 8'h77, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 15);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            int lo = $urandom_range(0, 15);
            int hi = $urandom_range(0, 15);
            if (r < 45)      step(1, 0, 0, $urandom_range(0, 255), 0, 0);
            else if (r < 88) step(0, 1, 0, 0, 0, 0);
            else if (r < 92) step(1, 1, 0, $urandom_range(0, 255), 0, 0);
            else if (r < 97) step(0, 0, 1, 0, lo, hi);
            else             step($urandom_range(0, 1), $urandom_range(0, 1), 1, 0, lo, hi);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule